// File: doc/BRIEF.md
# Dual-Port GPIO Register Bank

This block holds the control state for two 8-bit general-purpose ports. Each port has a drive-value register, an invert mask applied to what is read back from its pins, and a direction register. A host interface writes one byte per strobe to the register picked by a 3-bit index. A combinational read mux returns the register picked by a separate read index.

The block drives per-pin output values and active-high output enables for external tri-state pads. It samples live pin levels to form the input-port read value. Pad circuitry and any serial protocol engine sit outside the block.

Top module: `gpio_regbank`

## Requirements
- R1: Index encoding: idx[2:1] selects the kind of register (0 = pin input, 1 = drive value, 2 = invert mask, 3 = direction), and idx[0] selects port 0 (pins 7:0) or port 1 (pins 15:8).
- R2: After a synchronous reset with rst_n low, every drive-value register holds 8'hFF, every invert mask holds 8'h00, and every direction register holds 8'hFF. As a result, all output enables are low.
- R3: A write strobe at index 0 or 1 changes no register. A later read of every writable index returns its value from before the write.
- R4: Reading index 0 or 1 returns the live pin levels of that port XOR that port's invert mask, combinationally. This holds whether each pin is set as an input or an output.
- R5: A write to index 2..7 takes effect at the next rising clock edge. Only the addressed byte changes.
- R6: Reading index 2..7 returns the stored register byte. For index 2 or 3 this is the flip-flop value, whatever level the pin has.
- R7: For each pin, oe is the inverse of its direction bit: direction 1 means input and oe low, direction 0 means oe high.
- R8: The out vector always equals the drive-value registers. A pin whose direction bit is 1 is never enabled, whatever its drive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 3 | Write register index |
| wr_data | input | 8 | Write byte |
| rd_idx | input | 3 | Read register index |
| rd_data | output | 8 | Read byte (combinational) |
| pin_in | input | 16 | Live pin levels |
| pin_out | output | 16 | Drive value per pin |
| pin_oe | output | 16 | Output enable per pin, active high |

## Verification
A write is visible on rd_data, pin_out and pin_oe one clock edge after the strobe. Every task therefore drives its inputs on the falling edge and samples after the next rising edge plus a margin. Reads of the input registers are combinational: the bench changes pin_in or rd_idx away from any edge and samples a few nanoseconds later in the same cycle. Ignored writes to indices 0 and 1 are checked by reading back all six writable bytes and the pin vectors on the cycle after the strobe.

// File: rtl/gpio_regbank.sv
module gpio_regbank #(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [2:0]     wr_idx,
  input  logic [W-1:0]   wr_data,
  input  logic [2:0]     rd_idx,
  output logic [W-1:0]   rd_data,
  input  logic [2*W-1:0] pin_in,
  output logic [2*W-1:0] pin_out,
  output logic [2*W-1:0] pin_oe
);
  localparam int N = 2 * W;

  logic [N-1:0] drv_q, inv_q, dir_q;
  logic [N-1:0] pin_rd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drv_q <= '1;
      inv_q <= '0;
      dir_q <= '1;
    end else if (wr_en) begin
      case (wr_idx)
        3'd2: drv_q[W-1:0] <= wr_data;
        3'd3: drv_q[N-1:W] <= wr_data;
        3'd4: inv_q[W-1:0] <= wr_data;
        3'd5: inv_q[N-1:W] <= wr_data;
        3'd6: dir_q[W-1:0] <= wr_data;
        3'd7: dir_q[N-1:W] <= wr_data;
        default: ;
      endcase
    end
  end

  assign pin_rd  = pin_in ^ inv_q;
  assign pin_out = drv_q;
  assign pin_oe  = ~dir_q;

  always_comb begin
    case (rd_idx)
      3'd0: rd_data = pin_rd[W-1:0];
      3'd1: rd_data = pin_rd[N-1:W];
      3'd2: rd_data = drv_q[W-1:0];
      3'd3: rd_data = drv_q[N-1:W];
      3'd4: rd_data = inv_q[W-1:0];
      3'd5: rd_data = inv_q[N-1:W];
      3'd6: rd_data = dir_q[W-1:0];
      default: rd_data = dir_q[N-1:W];
    endcase
  end

  // R2
  rst_defaults_chk: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '1 && pin_oe == '0));

  // R3
  ro_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx[2:1] == 2'b00) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R5
  wr_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd2) |=> (pin_out[W-1:0] == $past(wr_data)));

  // R5
  wr_dir_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 3'd7) |=> (pin_oe[N-1:W] == ~$past(wr_data)));

  // R8
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(pin_out) && $stable(pin_oe)));

  // R6
  rd_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == 3'd3) |-> (rd_data == pin_out[N-1:W]));
endmodule

// File: tb/gpio_regbank_tb.sv
module gpio_regbank_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        wr_en = 0;
  logic [2:0]  wr_idx = 0;
  logic [7:0]  wr_data = 0;
  logic [2:0]  rd_idx = 0;
  logic [7:0]  rd_data;
  logic [15:0] pin_in = 0;
  logic [15:0] pin_out, pin_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_regbank u_dut (.*);

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] i, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_idx = i; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd_chk(string req, logic [2:0] i, logic [7:0] exp);
    rd_idx = i; #1;
    chk(req, {8'h0, rd_data}, {8'h0, exp});
  endtask

  task automatic t_reset;
    rst_n = 0; repeat (2) @(negedge clk); rst_n = 1;
    chk("R2 out", pin_out, 16'hFFFF);
    chk("R2 oe", pin_oe, 16'h0000);
    rd_chk("R2 drv0", 3'd2, 8'hFF);
    rd_chk("R2 inv1", 3'd5, 8'h00);
    rd_chk("R2 dir0", 3'd6, 8'hFF);
    rd_chk("R2 dir1", 3'd7, 8'hFF);
  endtask

  task automatic t_writes;
    wr(3'd2, 8'hA5); wr(3'd3, 8'h3C);
    wr(3'd4, 8'h0F); wr(3'd5, 8'hF0);
    wr(3'd6, 8'h81); wr(3'd7, 8'h00);
    rd_chk("R5 drv0", 3'd2, 8'hA5);
    rd_chk("R5 drv1", 3'd3, 8'h3C);
    rd_chk("R5 inv0", 3'd4, 8'h0F);
    rd_chk("R5 inv1", 3'd5, 8'hF0);
    rd_chk("R1 dir0", 3'd6, 8'h81);
    rd_chk("R1 dir1", 3'd7, 8'h00);
    chk("R8 out", pin_out, 16'h3CA5);
    chk("R7 oe", pin_oe, 16'hFF7E);
  endtask

  task automatic t_ro_write;
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    rd_chk("R3 drv0", 3'd2, 8'hA5);
    rd_chk("R3 drv1", 3'd3, 8'h3C);
    rd_chk("R3 inv0", 3'd4, 8'h0F);
    rd_chk("R3 inv1", 3'd5, 8'hF0);
    rd_chk("R3 dir0", 3'd6, 8'h81);
    rd_chk("R3 dir1", 3'd7, 8'h00);
    chk("R3 out", pin_out, 16'h3CA5);
    chk("R3 oe", pin_oe, 16'hFF7E);
  endtask

  task automatic t_input_read;
    pin_in = 16'h5A66;
    rd_chk("R4 in0", 3'd0, 8'h66 ^ 8'h0F);
    rd_chk("R4 in1", 3'd1, 8'h5A ^ 8'hF0);
    pin_in = 16'h0000;
    rd_chk("R4 in0 zero", 3'd0, 8'h0F);
    wr(3'd4, 8'h00);
    pin_in = 16'h00C3;
    rd_chk("R4 in0 plain", 3'd0, 8'hC3);
    rd_chk("R6 drv0 vs pin", 3'd2, 8'hA5);
  endtask

  task automatic t_single_byte;
    wr(3'd3, 8'h01);
    rd_chk("R5 drv0 untouched", 3'd2, 8'hA5);
    chk("R5 out", pin_out, 16'h01A5);
    wr(3'd6, 8'hFF);
    chk("R8 in-mode no oe", pin_oe & 16'h00FF, 16'h0000);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    t_reset;
    t_writes;
    t_ro_write;
    t_input_read;
    t_single_byte;
    t_reset;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule